// File: doc/BRIEF.md
# UART Hardware Flow Controller

This block runs the modem-control handshake of a UART without software help. On the receive side it watches the fill count of the receive FIFO and drives the active-low request-to-send line. The line is released (driven high) a table step above the chosen receive trigger level. It is pulled low again a table step below that level, so the remote sender sees a hysteresis band and not one switching point. The same trigger level also drives a receive-level interrupt. The receiver does not stop accepting characters when the line goes high; it keeps filling until the FIFO holds its full 16 entries.

On the transmit side the block brings the active-low clear-to-send input through a synchronizer. When the input is high, the block withholds permission for the local transmitter to start a new character, but a character already on the wire is allowed to finish. The request line going high and the clear line going high are each an interrupt source, and each can be enabled on its own. Both sources share one status flag. The flag stays set until a clear pulse arrives. The FIFO itself, the shift registers, the baud timing and the register bus live elsewhere.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `rts_n` is 1, `tx_allow` is 1, `rx_trig_irq` is 0 and `fc_irq` is 0.
- R2: With `rx_irq_en` set, `rx_trig_irq` is 1 on the cycle after `rx_count` is at least the trigger level and 0 otherwise. The trigger level is 1, 4, 8 or 14 for `trig_sel` = 0, 1, 2 or 3.
- R3: With `auto_rts_en` clear, `rts_n` equals the inverse of `sw_rts` one cycle later.
- R4: With `auto_rts_en` set and `sw_rts` clear, `rts_n` is 1. Setting `sw_rts` starts automatic control, and `rts_n` is 0 one cycle later if the count is below the release point.
- R5: Under automatic control, `rts_n` is 1 on the cycle after `rx_count` reaches the release point: 4, 8, 14 or 14 for `trig_sel` = 0..3.
- R6: Under automatic control, `rts_n` is 0 on the cycle after `rx_count` falls to the re-assert point or below: 0, 1, 4 or 8 for `trig_sel` = 0..3. Between the re-assert and release points, `rts_n` keeps its value.
- R7: A 0-to-1 transition of `rts_n` sets the status flag, so that `fc_irq` is 1 in the same cycle that `rts_n` is 1. This happens only when `rts_irq_en` is set.
- R8: With `auto_cts_en` set and `tx_busy` clear, `tx_allow` goes to 0 SYNC_STAGES+1 cycles after `cts_n` rises. It returns to 1 SYNC_STAGES+1 cycles after `cts_n` falls.
- R9: While `tx_busy` is 1, `tx_allow` does not fall. The suspension takes effect on the cycle after `tx_busy` drops.
- R10: With `auto_cts_en` clear, `tx_allow` stays 1 whatever `cts_n` does.
- R11: When `cts_irq_en` is set, a rise of the synchronized `cts_n` sets the status flag (`fc_irq` = 1) SYNC_STAGES+1 cycles after `cts_n` rises. When it is clear, the flag is not set.
- R12: Once set, the status flag stays set until `flag_clr` is 1. After a clear pulse, `fc_irq` is 0 on the next cycle. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_count | input | CNT_W | Characters currently held in the receive FIFO |
| trig_sel | input | 2 | Receive trigger select (0..3 → 1, 4, 8, 14) |
| auto_rts_en | input | 1 | Enables automatic request-to-send control |
| sw_rts | input | 1 | Software request bit; starts automatic control |
| auto_cts_en | input | 1 | Enables transmit suspension by clear-to-send |
| rx_irq_en | input | 1 | Enables the receive trigger interrupt |
| rts_irq_en | input | 1 | Enables the flag on request line release |
| cts_irq_en | input | 1 | Enables the flag on clear line release |
| cts_n | input | 1 | Asynchronous active-low clear-to-send |
| tx_busy | input | 1 | Transmitter is in the middle of a character |
| flag_clr | input | 1 | Clears the shared status flag |
| rts_n | output | 1 | Active-low request-to-send |
| tx_allow | output | 1 | Transmitter may start a new character |
| rx_trig_irq | output | 1 | Receive trigger-level interrupt |
| fc_irq | output | 1 | Flow-control status flag and interrupt |

## Verification
The bench builds the block with FIFO_DEPTH = 16 and SYNC_STAGES = 2. With these values all four trigger table rows are reachable, including the top row, where the release point equals the trigger. The bench sweeps every row across its re-assert, hold and release counts. The two-stage synchronizer fixes the clear-to-send latency at three cycles. The bench checks both edges of `tx_allow` and of the flag at that exact cycle, and it also checks the case where a busy transmitter postpones the suspension.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    localparam int unsigned TRIG_SEL_W = 2;

    typedef enum logic [TRIG_SEL_W-1:0] {
        TRIG_ONE      = 2'd0,
        TRIG_FOUR     = 2'd1,
        TRIG_EIGHT    = 2'd2,
        TRIG_FOURTEEN = 2'd3
    } trig_sel_e;

    // the three fill counts tied to one trigger selection
    typedef struct packed {
        logic [7:0] fire;
        logic [7:0] off_at;
        logic [7:0] on_at;
    } trig_points_t;

    // events passed to the flag logic
    typedef struct packed {
        logic rts_rise;
        logic cts_release;
    } fc_event_t;

    function automatic trig_points_t trig_points(trig_sel_e sel);
        trig_points_t p;
        case (sel)
            TRIG_ONE:      p = '{fire: 8'd1,  off_at: 8'd4,  on_at: 8'd0};
            TRIG_FOUR:     p = '{fire: 8'd4,  off_at: 8'd8,  on_at: 8'd1};
            TRIG_EIGHT:    p = '{fire: 8'd8,  off_at: 8'd14, on_at: 8'd4};
            default:       p = '{fire: 8'd14, off_at: 8'd14, on_at: 8'd8};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RESET_VAL;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RESET_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/fc_rts_ctrl.sv
module fc_rts_ctrl #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] off_at,
    input  logic [CNT_W-1:0] on_at,
    input  logic             auto_rts_en,
    input  logic             sw_rts,
    output logic             rts_n,
    output logic             rts_rise
);
    logic rts_q, rts_d;
    logic armed_q, armed_d;
    logic at_off, at_on;

    assign at_off = (rx_count >= off_at);
    assign at_on  = (rx_count <= on_at);

    always_comb begin
        rts_d   = rts_q;
        armed_d = armed_q;
        if (!(auto_rts_en && sw_rts)) begin
            rts_d   = ~sw_rts;
            armed_d = 1'b0;
        end else if (!armed_q) begin
            rts_d   = at_off;
            armed_d = 1'b1;
        end else if (at_off) begin
            rts_d = 1'b1;
        end else if (at_on) begin
            rts_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rts_q   <= 1'b1;
            armed_q <= 1'b0;
        end else begin
            rts_q   <= rts_d;
            armed_q <= armed_d;
        end
    end

    assign rts_n    = rts_q;
    assign rts_rise = rts_d & ~rts_q;

    a_r3_manual_follow: assert property (@(posedge clk) disable iff (rst)
        !auto_rts_en |=> (rts_n == !$past(sw_rts)));
    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        (auto_rts_en && sw_rts && at_off) |=> rts_n);
    a_r6_reassert: assert property (@(posedge clk) disable iff (rst)
        (auto_rts_en && sw_rts && at_on && !at_off) |=> !rts_n);
    a_r4_idle_high: assert property (@(posedge clk) disable iff (rst)
        (auto_rts_en && !sw_rts) |=> rts_n);
endmodule

// File: rtl/fc_cts_gate.sv
module fc_cts_gate (
    input  logic clk,
    input  logic rst,
    input  logic auto_cts_en,
    input  logic cts_s,
    input  logic tx_busy,
    output logic tx_allow,
    output logic cts_release
);
    logic hold_q;
    logic cts_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= 1'b0;
            cts_prev_q <= 1'b0;
        end else begin
            cts_prev_q <= cts_s;
            if (!auto_cts_en || !cts_s) hold_q <= 1'b0;
            else if (!tx_busy)          hold_q <= 1'b1;
        end
    end

    assign tx_allow    = ~hold_q;
    assign cts_release = cts_s & ~cts_prev_q;

    a_r10_no_auto: assert property (@(posedge clk) disable iff (rst)
        !auto_cts_en |=> tx_allow);
    a_r9_frame_done: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && tx_allow) |=> tx_allow);
endmodule

// File: rtl/fc_irq_ctrl.sv
module fc_irq_ctrl #(
    parameter int unsigned CNT_W = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CNT_W-1:0]      rx_count,
    input  logic [CNT_W-1:0]      fire_at,
    input  logic                  rx_irq_en,
    input  logic                  rts_irq_en,
    input  logic                  cts_irq_en,
    input  uart_fc_pkg::fc_event_t ev,
    input  logic                  flag_clr,
    output logic                  rx_trig_irq,
    output logic                  fc_irq
);
    logic flag_q, rx_q, set_flag;

    assign set_flag = (ev.rts_rise & rts_irq_en) | (ev.cts_release & cts_irq_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            rx_q   <= 1'b0;
        end else begin
            rx_q <= rx_irq_en && (rx_count >= fire_at);
            if (set_flag)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign rx_trig_irq = rx_q;
    assign fc_irq      = flag_q;

    a_r7_rts_flag: assert property (@(posedge clk) disable iff (rst)
        (ev.rts_rise && rts_irq_en) |=> fc_irq);
    a_r11_cts_flag: assert property (@(posedge clk) disable iff (rst)
        (ev.cts_release && cts_irq_en) |=> fc_irq);
    a_r12_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (fc_irq && !flag_clr) |=> fc_irq);
    a_r12_flag_clears: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !ev.rts_rise && !ev.cts_release) |=> !fc_irq);
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import uart_fc_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH  = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic             auto_rts_en,
    input  logic             sw_rts,
    input  logic             auto_cts_en,
    input  logic             rx_irq_en,
    input  logic             rts_irq_en,
    input  logic             cts_irq_en,
    input  logic             cts_n,
    input  logic             tx_busy,
    input  logic             flag_clr,
    output logic             rts_n,
    output logic             tx_allow,
    output logic             rx_trig_irq,
    output logic             fc_irq
);
    trig_points_t     pts;
    logic [CNT_W-1:0] fire_at, off_at, on_at;
    logic             cts_s;
    fc_event_t        ev;

    assign pts     = trig_points(trig_sel_e'(trig_sel));
    assign fire_at = CNT_W'(pts.fire);
    assign off_at  = CNT_W'(pts.off_at);
    assign on_at   = CNT_W'(pts.on_at);

    fc_rts_ctrl #(.CNT_W(CNT_W)) u_rts (
        .clk(clk), .rst(rst), .rx_count(rx_count), .off_at(off_at), .on_at(on_at),
        .auto_rts_en(auto_rts_en), .sw_rts(sw_rts), .rts_n(rts_n), .rts_rise(ev.rts_rise)
    );

    fc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
        .clk(clk), .rst(rst), .d_async(cts_n), .q_sync(cts_s)
    );

    fc_cts_gate u_cts (
        .clk(clk), .rst(rst), .auto_cts_en(auto_cts_en), .cts_s(cts_s),
        .tx_busy(tx_busy), .tx_allow(tx_allow), .cts_release(ev.cts_release)
    );

    fc_irq_ctrl #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst(rst), .rx_count(rx_count), .fire_at(fire_at),
        .rx_irq_en(rx_irq_en), .rts_irq_en(rts_irq_en), .cts_irq_en(cts_irq_en),
        .ev(ev), .flag_clr(flag_clr), .rx_trig_irq(rx_trig_irq), .fc_irq(fc_irq)
    );
endmodule

// File: tb/tb_uart_flow_ctrl.sv
module tb_uart_flow_ctrl;
    localparam int unsigned DEPTH = 16;
    localparam int unsigned SYNC  = 2;
    localparam int unsigned CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CW-1:0] rx_count = '0;
    logic [1:0] trig_sel = '0;
    logic auto_rts_en = 0, sw_rts = 0, auto_cts_en = 0, rx_irq_en = 0;
    logic rts_irq_en = 0, cts_irq_en = 0, cts_n = 0, tx_busy = 0, flag_clr = 0;
    logic rts_n, tx_allow, rx_trig_irq, fc_irq;

    always #2.5 clk = ~clk;

    uart_flow_ctrl #(.FIFO_DEPTH(DEPTH), .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst(rst), .rx_count(rx_count), .trig_sel(trig_sel),
        .auto_rts_en(auto_rts_en), .sw_rts(sw_rts), .auto_cts_en(auto_cts_en),
        .rx_irq_en(rx_irq_en), .rts_irq_en(rts_irq_en), .cts_irq_en(cts_irq_en),
        .cts_n(cts_n), .tx_busy(tx_busy), .flag_clr(flag_clr),
        .rts_n(rts_n), .tx_allow(tx_allow), .rx_trig_irq(rx_trig_irq), .fc_irq(fc_irq)
    );

    typedef struct {
        logic [3:0] mask;   // {rts_n, tx_allow, rx_trig_irq, fc_irq}
        logic [3:0] val;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, errors = 0;
    bit done = 0;

    function automatic int lvl_fire(int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
    endfunction
    function automatic int lvl_off(int s);
        return (s == 0) ? 4 : (s == 1) ? 8 : 14;
    endfunction
    function automatic int lvl_on(int s);
        return (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 4 : 8;
    endfunction

    // push an expectation checked right after the next rising edge, then advance one cycle
    task automatic chk(input logic [3:0] mask, input logic [3:0] val, input string tag);
        exp_t e;
        e.mask = mask; e.val = val; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic chk_rts(input logic v, input string tag);
        chk(4'b1000, {v, 3'b000}, tag);
    endtask
    task automatic chk_tx(input logic v, input string tag);
        chk(4'b0100, {1'b0, v, 2'b00}, tag);
    endtask
    task automatic chk_rx(input logic v, input string tag);
        chk(4'b0010, {2'b00, v, 1'b0}, tag);
    endtask
    task automatic chk_fc(input logic v, input string tag);
        chk(4'b0001, {3'b000, v}, tag);
    endtask

    // monitor: compare after every rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [3:0] act;
                e   = exp_q.pop_front();
                act = {rts_n, tx_allow, rx_trig_irq, fc_irq};
                checks++;
                if ((act & e.mask) !== (e.val & e.mask)) begin
                    errors++;
                    $display("FAIL %s: actual %b expected %b (mask %b)", e.tag, act, e.val, e.mask);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 reset values
        chk(4'b1111, 4'b1100, "R1 in reset");
        rst = 0;
        chk(4'b1111, 4'b1100, "R1 after reset");

        // R3 manual mode
        sw_rts = 1; chk_rts(0, "R3 sw set");
        sw_rts = 0; chk(4'b1001, 4'b1000, "R3 sw clear, R7 no flag when disabled");

        // R2 receive trigger per row
        rx_irq_en = 1;
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            rx_count = CW'(lvl_fire(s) - 1); chk_rx(0, "R2 below trigger");
            rx_count = CW'(lvl_fire(s));     chk_rx(1, "R2 at trigger");
        end
        rx_irq_en = 0; rx_count = '0; trig_sel = 0;
        chk_rx(0, "R2 disabled");

        // R4 start of automatic control
        auto_rts_en = 1; sw_rts = 0; chk_rts(1, "R4 enabled not started");
        sw_rts = 1;                  chk_rts(0, "R4 started");

        // R5 R6 R7 R12 hysteresis per row
        rts_irq_en = 1;
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            rx_count = CW'(lvl_on(s));      chk_rts(0, "R6 at reassert point");
            rx_count = CW'(lvl_off(s) - 1); chk_rts(0, "R5 just below release");
            rx_count = CW'(lvl_off(s));     chk(4'b1001, 4'b1001, "R5 release with R7 flag");
            rx_count = DEPTH[CW-1:0];       chk(4'b1001, 4'b1001, "R12 flag held, full FIFO");
            flag_clr = 1;                   chk(4'b1001, 4'b1000, "R12 flag cleared");
            flag_clr = 0;
            rx_count = CW'(lvl_on(s) + 1);  chk_rts(1, "R6 hold inside band");
            rx_count = CW'(lvl_on(s));      chk_rts(0, "R6 reassert");
        end
        rts_irq_en = 0;
        rx_count = CW'(lvl_off(3)); chk(4'b1001, 4'b1000, "R7 rise without enable");
        rx_count = 0; auto_rts_en = 0; sw_rts = 0;
        chk_rts(1, "R3 back to manual");

        // R8 R11 clear-to-send path
        auto_cts_en = 1; cts_irq_en = 1;
        cts_n = 1;
        for (int i = 0; i < SYNC; i++) chk_tx(1, "R8 before sync delay");
        chk(4'b0101, 4'b0001, "R8 suspended, R11 flag");
        cts_n = 0;
        for (int i = 0; i < SYNC; i++) chk_tx(0, "R8 still suspended");
        chk_tx(1, "R8 resumed");
        flag_clr = 1; chk_fc(0, "R12 clear after cts");
        flag_clr = 0;

        // R9 busy transmitter defers suspension
        tx_busy = 1; cts_n = 1;
        for (int i = 0; i < SYNC + 3; i++) chk_tx(1, "R9 frame in progress");
        tx_busy = 0; chk_tx(0, "R9 suspended after frame");
        cts_n = 0;
        for (int i = 0; i < SYNC; i++) chk_tx(0, "R9 waiting release");
        chk_tx(1, "R9 resumed");
        flag_clr = 1; chk_fc(0, "R12 clear");
        flag_clr = 0;

        // R11 no flag when disabled
        cts_irq_en = 0; cts_n = 1;
        for (int i = 0; i < SYNC + 2; i++) @(negedge clk);
        chk(4'b0101, 4'b0000, "R11 no flag when disabled");
        cts_n = 0;
        for (int i = 0; i < SYNC + 2; i++) @(negedge clk);

        // R10 automatic clear-to-send off
        auto_cts_en = 0; cts_n = 1;
        for (int i = 0; i < SYNC + 2; i++) chk_tx(1, "R10 ignored cts");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule